// File: doc/BRIEF.md
# Accumulator-Trimmed Nanosecond Clock

This block keeps a nanosecond time counter that is advanced once per oscillator cycle (nominally 125 MHz, so 8 ns per cycle) and trims its rate in whole-nanosecond steps. The trim amount is an unsigned addend with a separate sign. While trimming is on, the addend is summed into a 30-bit phase accumulator every cycle. On each cycle where that sum carries out, the step for that cycle becomes 9 ns for a positive sign or 7 ns for a negative sign.

Software programs the block through a 16-bit word-write port. A five-word sequence to the drift index loads a new addend and sign. The new pair takes effect together once the last word has been written. A separate status index holds the enable bit. The addend needed for a given carry rate is 2^30 times that rate divided by the oscillator frequency. The largest allowed rate is half the oscillator frequency, which is 0.5 ns per cycle or 6.25 %.

Top module: `drift_trim`

## Requirements
- R1: After an asynchronous active-low reset, `ns_count` is 0, `inc_ns` is 8, trimming is off, and the addend and accumulator are 0.
- R2: While enable bit 12 of the status word (index 0x08) is clear, `inc_ns` is 8 on every cycle, whatever addend is loaded, and the accumulator holds its value.
- R3: With trimming on and an addend of 0, `inc_ns` stays at exactly 8 on every cycle.
- R4: With trimming on and a positive sign, on each cycle `inc_ns` is 9 when accumulator plus addend reaches 2^30, and 8 otherwise. The accumulator then takes that sum modulo 2^30.
- R5: With a negative sign, the overflow cycles of R4 give `inc_ns` = 7 instead of 9.
- R6: Writes to index 0x10 form a sequence of five words. Word 1 carries the sign in bit 15 (1 = negative). Words 2 and 3 are ignored. Word 4 is addend bits 31:16 and word 5 is addend bits 15:0. The new addend and sign apply together from the cycle after word 5 is written. Until then, the previous pair stays in use.
- R7: The accumulator residue is kept when a new addend is loaded and while trimming is off.
- R8: An addend of 2^29 or more is clamped to 2^29. Two consecutive cycles never both have an increment other than 8.
- R9: On each cycle, `ns_count` advances by that cycle's `inc_ns`, modulo `WRAP_NS` (10^9 by default).
- R10: Writes to any other index have no effect on the increment, the counter, or an unfinished drift sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Word write strobe |
| reg_idx | input | 6 | Word index of the write |
| reg_wdata | input | 16 | Write data |
| inc_ns | output | 4 | Step applied to the counter this cycle (7, 8 or 9) |
| ns_count | output | 30 | Nanosecond counter |

## Verification
A wrong accumulator residue or addend does not show at once. It appears as a 7 or 9 step on the wrong cycle, which can be up to 2^30/addend cycles later, and from then on `ns_count` stays off by one nanosecond. A dropped or misordered drift word shows up as a change in carry spacing, starting in the cycle after the fifth word. The bench therefore compares both outputs on every cycle against a cycle-exact model, over long runs with varied addends. A reduced wrap limit brings the counter wrap within reach.

// File: rtl/drift_trim.sv
module drift_trim #(
  parameter int ADDR_W     = 6,
  parameter int DRIFT_IDX  = 'h10,
  parameter int STATUS_IDX = 'h08,
  parameter int ENA_BIT    = 12,
  parameter int NOM_NS     = 8,
  parameter int ACC_W      = 30,
  parameter int NS_W       = 30,
  parameter int WRAP_NS    = 1000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_idx,
  input  logic [15:0]       reg_wdata,
  output logic [3:0]        inc_ns,
  output logic [NS_W-1:0]   ns_count
);
  localparam logic [31:0]      LIM32   = 32'd1 << (ACC_W-1);
  localparam logic [ACC_W-1:0] ADD_MAX = ACC_W'(LIM32);
  localparam logic [NS_W:0]    WRAP    = (NS_W+1)'(WRAP_NS);
  localparam logic [3:0]       NOM     = 4'(NOM_NS);

  logic [2:0]       word_q;
  logic             sign_stg;
  logic [15:0]      hi_stg;
  logic             neg_q, ena_q;
  logic [ACC_W-1:0] add_q, acc_q;
  logic [NS_W-1:0]  cnt_q;

  wire drift_we  = reg_we && (reg_idx == ADDR_W'(DRIFT_IDX));
  wire status_we = reg_we && (reg_idx == ADDR_W'(STATUS_IDX));
  wire [31:0] raw = {hi_stg, reg_wdata};
  wire [ACC_W-1:0] add_new = (raw >= LIM32) ? ADD_MAX : raw[ACC_W-1:0];

  wire [ACC_W:0] acc_sum = {1'b0, acc_q} + {1'b0, add_q};
  wire carry = ena_q & acc_sum[ACC_W];

  assign inc_ns = !carry ? NOM : (neg_q ? NOM - 4'd1 : NOM + 4'd1);

  wire [NS_W:0] cnt_sum = {1'b0, cnt_q} + (NS_W+1)'(inc_ns);
  wire [NS_W:0] cnt_nxt = (cnt_sum >= WRAP) ? cnt_sum - WRAP : cnt_sum;
  assign ns_count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      sign_stg <= 1'b0;
      hi_stg   <= '0;
      neg_q    <= 1'b0;
      ena_q    <= 1'b0;
      add_q    <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_nxt[NS_W-1:0];
      if (ena_q) acc_q <= acc_sum[ACC_W-1:0];
      if (status_we) ena_q <= reg_wdata[ENA_BIT];
      if (drift_we) begin
        word_q <= (word_q == 3'd4) ? 3'd0 : word_q + 3'd1;
        case (word_q)
          3'd0: sign_stg <= reg_wdata[15];
          3'd3: hi_stg   <= reg_wdata;
          3'd4: begin
            add_q <= add_new;
            neg_q <= sign_stg;
          end
          default: ;
        endcase
      end
    end
  end

  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ns != NOM) |=> (inc_ns == NOM)); // R8
  AST_ADD_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    add_q <= ADD_MAX); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(add_q) && $stable(neg_q))); // R6
  AST_RESIDUE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_q |=> $stable(acc_q)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ns_count} < WRAP); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(ns_count) == (int'($past(ns_count)) + int'($past(inc_ns))) % WRAP_NS); // R9
endmodule

// File: tb/sim_drift_trim.sv
module sim_drift_trim;
  localparam int WRAP = 1000;
  localparam longint TWO30 = 64'd1 << 30;
  localparam longint TWO29 = 64'd1 << 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_idx = '0;
  logic [15:0] reg_wdata = '0;
  logic [3:0] inc_ns;
  logic [29:0] ns_count;

  drift_trim #(.WRAP_NS(WRAP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .inc_ns(inc_ns), .ns_count(ns_count));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  string tag = "R1";
  int ovf_seen = 0;

  longint m_acc = 0, m_add = 0, m_hi = 0;
  bit m_neg = 0, m_en = 0, m_sstg = 0;
  int m_cnt = 0, m_word = 0;

  task automatic chk(string t, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic int exp_inc();
    if (m_en && (m_acc + m_add >= TWO30)) return m_neg ? 7 : 9;
    return 8;
  endfunction

  task automatic cyc(bit we, logic [5:0] idx, logic [15:0] d);
    int e = exp_inc();
    longint raw;
    chk(tag, inc_ns, e);
    chk(tag, ns_count, m_cnt);
    if (e != 8) ovf_seen++;
    reg_we = we; reg_idx = idx; reg_wdata = d;
    if (m_en) m_acc = (m_acc + m_add) % TWO30;
    m_cnt = (m_cnt + e) % WRAP;
    if (we && idx == 6'h08) m_en = d[12];
    if (we && idx == 6'h10) begin
      case (m_word)
        0: m_sstg = d[15];
        3: m_hi = d;
        4: begin
          raw = (m_hi << 16) | d;
          m_add = (raw >= TWO29) ? TWO29 : raw;
          m_neg = m_sstg;
        end
        default: ;
      endcase
      m_word = (m_word == 4) ? 0 : m_word + 1;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 6'h00, 16'h0);
  endtask

  task automatic load(bit neg, logic [31:0] a);
    cyc(1, 6'h10, {neg, 15'h0});
    cyc(1, 6'h10, 16'h0);
    cyc(1, 6'h10, 16'h0);
    cyc(1, 6'h10, a[31:16]);
    cyc(1, 6'h10, a[15:0]);
  endtask

  initial begin
    #(20 * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nz, prev;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", inc_ns, 8);
    chk("R1", ns_count, 0);
    rst_n = 1'b1;
    idle(5);

    tag = "R3";
    cyc(1, 6'h08, 16'h1000);
    idle(30);

    tag = "R2";
    cyc(1, 6'h08, 16'h0000);
    load(0, 32'h1000_0000);
    ovf_seen = 0;
    idle(40);
    chk("R2", ovf_seen, 0);

    tag = "R4";
    cyc(1, 6'h08, 16'h1000);
    ovf_seen = 0;
    idle(40);
    chk("R4", ovf_seen, 10);

    tag = "R10";
    cyc(1, 6'h10, 16'h8000);
    cyc(1, 6'h08, 16'h1000);
    cyc(1, 6'h11, 16'hFFFF);
    cyc(1, 6'h10, 16'h0);
    cyc(1, 6'h0F, 16'h8000);
    idle(8);
    tag = "R6";
    cyc(1, 6'h10, 16'h0);
    idle(6);
    cyc(1, 6'h10, 16'h0400);
    idle(5);
    cyc(1, 6'h10, 16'h0000);
    idle(30);

    tag = "R5";
    load(1, 32'h0123_4567);
    ovf_seen = 0;
    idle(200);
    chk("R5", ovf_seen > 0, 1);

    tag = "R7";
    cyc(1, 6'h08, 16'h0000);
    idle(15);
    cyc(1, 6'h08, 16'h1000);
    idle(30);
    load(0, 32'h0200_0000);
    idle(30);

    tag = "R8";
    load(0, 32'hFFFF_FFFF);
    idle(3);
    nz = 0;
    for (int i = 0; i < 40; i++) begin
      if (inc_ns != 8) nz++;
      cyc(0, 6'h00, 16'h0);
    end
    chk("R8", nz, 20);
    prev = 8;
    for (int i = 0; i < 20; i++) begin
      chk("R8", (prev != 8) && (inc_ns != 8), 0);
      prev = inc_ns;
      cyc(0, 6'h00, 16'h0);
    end

    tag = "R9";
    idle(300);

    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      if (r < 4) cyc(1, 6'h10, 16'($urandom));
      else if (r < 5) cyc(1, 6'h08, {3'b000, 1'($urandom % 4 != 0), 12'h0});
      else if (r < 6) cyc(1, 6'($urandom), 16'($urandom));
      else cyc(0, 6'h00, 16'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule